// File: doc/BRIEF.md
# Lock-Guarded GPIO Configuration Commit Bank

This block is the configuration register bank of one 8-pin GPIO port. It holds four per-pin configuration registers: alternate-function select, pull-up enable, pull-down enable and digital enable. A per-pin commit mask decides which bits of those registers a write may change. A configuration write changes only the bits whose mask bit is 1. Every other bit keeps its old value.

Pins named in a compile-time protected set, typically the debug or non-maskable-interrupt pins, reset with their mask bit at 0. The mask can be written only after software opens a key-guarded lock. Changing a protected pin's configuration therefore takes three deliberate writes: the key, the mask bit, then the configuration register. The mask bits of pins outside the protected set are fixed at 1, so configuration writes to those pins always take effect.

The bank sits on a simple synchronous register bus with a byte address, a write strobe, write data, a read strobe and combinational read data. The four configuration registers also drive output ports toward the pin logic.

Top module: `gpio_commit_bank`

## Requirements
- R1: Register map: alternate-function at 0x500, pull-up at 0x504, pull-down at 0x508, digital enable at 0x50C. A write to any of these sets bit i to the written bit where commit-mask bit i is 1 and leaves bit i unchanged where it is 0. Each register reads back in bits 7:0 and drives its own output port.
- R2: While the lock reads locked, writes to the commit mask are discarded and the mask keeps its value.
- R3: For each pin in the parameter PROT_PINS (default 8'h0F), the commit-mask bit resets to 0. Such a pin's configuration changes only after this sequence: unlock, set its mask bit, write the configuration register.
- R4: For each pin not in PROT_PINS, the commit-mask bit always reads 1. Writing 0 to it has no effect.
- R5: The commit mask sits at offset 0x524 with the mask in bits 7:0. Bits 31:8 of the mask and of every configuration register always read 0.
- R6: The lock sits at offset 0x520. Writing 0x4C4F434B unlocks it and writing any other value locks it. It reads 0 when unlocked and 1 when locked, and it resets to locked.
- R7: The reset values of the four configuration registers are parameters. The defaults are alternate-function 8'h0F, pull-up 8'h00, pull-down 8'h00 and digital enable 8'h0F.
- R8: A write takes effect at the rising clock edge on which the write strobe is sampled. Read data is valid in the same cycle as the read strobe and is 0 while the read strobe is low.
- R9: Writes to unmapped offsets change nothing, and reads from unmapped offsets return 0.
- R10: An active-low asynchronous reset restores the lock, the commit mask and all four configuration registers to their reset values at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| alt_sel_o | output | 8 | Alternate-function select per pin |
| pull_up_o | output | 8 | Pull-up enable per pin |
| pull_dn_o | output | 8 | Pull-down enable per pin |
| dig_en_o | output | 8 | Digital enable per pin |

## Verification
The bench checks the mask at the protected-pin boundary: a design that applied the mask to whole registers, or that used the reset mask in place of the current one, would read back mixed values such as 0xAF and 0x0C wrongly. It tries to clear the mask while locked and writes a near-miss key that differs by one bit. A design with a loose lock compare or a missing lock gate would show a changed mask. It also writes zeros to the hardwired mask bits, writes ones into the reserved upper bits, and touches unmapped offsets. It drops reset between clock edges and checks that all outputs return to their reset values at once.

// File: rtl/gpio_cmt_pkg.sv
package gpio_cmt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ALT  = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_PU   = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_PD   = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_DEN  = 12'h50C;
  localparam logic [ADDR_W-1:0] OFS_LOCK = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h524;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

  typedef struct packed {
    logic [3:0] cfg;   // 0 alt, 1 pull-up, 2 pull-down, 3 digital enable
    logic       lock;
    logic       mask;
  } reg_hit_t;
endpackage

// File: rtl/gpio_lock_ctl.sv
module gpio_lock_ctl
  import gpio_cmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != UNLOCK_KEY);
  end

  assign locked_o = locked_q;

  a_r6_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == UNLOCK_KEY) |=> !locked_o);
  a_r6_other_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != UNLOCK_KEY) |=> locked_o);
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(locked_o));
endmodule

// File: rtl/gpio_commit_mask.sv
module gpio_commit_mask #(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] PROT_PINS = 8'h0F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                locked_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] mask_o
);
  logic wr_ok;
  assign wr_ok = wr_i && !locked_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    if (PROT_PINS[i]) begin : g_prot
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    bit_q <= 1'b0;
        else if (wr_ok) bit_q <= wdata_i[i];
      end
      assign mask_o[i] = bit_q;
    end else begin : g_fixed
      assign mask_o[i] = 1'b1;  // unprotected pins always commit
    end
  end

  a_r2_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && locked_i) |=> $stable(mask_o));
  a_r2_unlocked_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !locked_i) |=> ((mask_o & PROT_PINS) == ($past(wdata_i) & PROT_PINS)));
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int                  NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] RST_VAL  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (wr_i) q <= (q & ~mask_i) | (wdata_i & mask_i);
  end

  assign q_o = q;

  a_r1_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0));
  a_r1_commit_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & $past(mask_i)) == ($past(wdata_i) & $past(mask_i))));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_commit_bank.sv
module gpio_commit_bank
  import gpio_cmt_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] PROT_PINS = 8'h0F,
  parameter logic [NUM_PINS-1:0] ALT_RST   = 8'h0F,
  parameter logic [NUM_PINS-1:0] PU_RST    = 8'h00,
  parameter logic [NUM_PINS-1:0] PD_RST    = 8'h00,
  parameter logic [NUM_PINS-1:0] DEN_RST   = 8'h0F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                rd_en_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] alt_sel_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic [NUM_PINS-1:0] dig_en_o
);
  localparam int NUM_CFG = 4;
  localparam int PAD_W   = DATA_W - NUM_PINS;
  localparam logic [NUM_CFG-1:0][NUM_PINS-1:0] CFG_RST = {DEN_RST, PD_RST, PU_RST, ALT_RST};

  reg_hit_t            hit;
  logic                locked;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg_q;

  always_comb begin
    hit = '0;
    unique case (addr_i)
      OFS_ALT:  hit.cfg[0] = 1'b1;
      OFS_PU:   hit.cfg[1] = 1'b1;
      OFS_PD:   hit.cfg[2] = 1'b1;
      OFS_DEN:  hit.cfg[3] = 1'b1;
      OFS_LOCK: hit.lock   = 1'b1;
      OFS_MASK: hit.mask   = 1'b1;
      default:  hit = '0;
    endcase
  end

  gpio_lock_ctl u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && hit.lock),
    .wdata_i  (wdata_i),
    .locked_o (locked)
  );

  gpio_commit_mask #(
    .NUM_PINS  (NUM_PINS),
    .PROT_PINS (PROT_PINS)
  ) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && hit.mask),
    .locked_i (locked),
    .wdata_i  (wdata_i[NUM_PINS-1:0]),
    .mask_o   (mask)
  );

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    gpio_cfg_reg #(
      .NUM_PINS (NUM_PINS),
      .RST_VAL  (CFG_RST[k])
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && hit.cfg[k]),
      .wdata_i (wdata_i[NUM_PINS-1:0]),
      .mask_i  (mask),
      .q_o     (cfg_q[k])
    );
  end

  assign alt_sel_o = cfg_q[0];
  assign pull_up_o = cfg_q[1];
  assign pull_dn_o = cfg_q[2];
  assign dig_en_o  = cfg_q[3];

  logic [NUM_PINS-1:0] rd_field;
  always_comb begin
    rd_field = '0;
    for (int k = 0; k < NUM_CFG; k++)
      if (hit.cfg[k]) rd_field = cfg_q[k];
    if (hit.mask) rd_field = mask;
    if (hit.lock) rd_field = NUM_PINS'(locked);
  end

  assign rdata_o = rd_en_i ? {{PAD_W{1'b0}}, rd_field} : '0;

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit == '0) |-> rdata_o == '0);
  a_r5_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_PINS] == '0);
  a_r4_fixed_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit.mask) |-> ((rdata_o[NUM_PINS-1:0] & ~PROT_PINS) == ~PROT_PINS));
  a_r9_unmapped_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit == '0) |=> ($stable(cfg_q) && $stable(mask) && $stable(locked)));
endmodule

// File: tb/gpio_commit_bank_bench.sv
module gpio_commit_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  alt_sel, pull_up, pull_dn, dig_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_commit_bank u_gpio_commit_bank (
    .clk_i (clk), .rst_ni (rst_ni), .addr_i (addr), .wr_en_i (wr_en),
    .wdata_i (wdata), .rd_en_i (rd_en), .rdata_o (rdata),
    .alt_sel_o (alt_sel), .pull_up_o (pull_up), .pull_dn_o (pull_dn), .dig_en_o (dig_en)
  );

  typedef struct packed {
    logic        wr;    // 1 write, 0 read-and-check
    logic [11:0] addr;
    logic [31:0] data;  // write data or expected read data
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h520, 32'h1},          // R6 reset locked
    '{1'b0, 12'h524, 32'hF0},         // R3 R4 reset mask
    '{1'b0, 12'h500, 32'h0F},         // R7 alt reset
    '{1'b0, 12'h50C, 32'h0F},         // R7 den reset
    '{1'b1, 12'h500, 32'hAA},
    '{1'b0, 12'h500, 32'hAF},         // R1 protected bits held
    '{1'b1, 12'h524, 32'hFF},
    '{1'b0, 12'h524, 32'hF0},         // R2 mask write while locked
    '{1'b1, 12'h520, 32'h4C4F434B},
    '{1'b0, 12'h520, 32'h0},          // R6 unlocked
    '{1'b1, 12'h524, 32'h03},
    '{1'b0, 12'h524, 32'hF3},         // R4 fixed ones survive 0 write
    '{1'b1, 12'h500, 32'h00},
    '{1'b0, 12'h500, 32'h0C},         // R3 three-step sequence
    '{1'b1, 12'h504, 32'hFFFFFFFF},
    '{1'b0, 12'h504, 32'hF3},         // R1 R5 pull-up, upper bits 0
    '{1'b1, 12'h508, 32'h5A},
    '{1'b0, 12'h508, 32'h52},         // R1 pull-down
    '{1'b1, 12'h50C, 32'h00},
    '{1'b0, 12'h50C, 32'h0C},         // R1 digital enable
    '{1'b1, 12'h524, 32'hFFFFFF00},
    '{1'b0, 12'h524, 32'hF0},         // R5 reserved bits read 0
    '{1'b1, 12'h520, 32'h4C4F434A},
    '{1'b0, 12'h520, 32'h1},          // R6 near-miss key locks
    '{1'b1, 12'h524, 32'hFF},
    '{1'b0, 12'h524, 32'hF0},         // R2 relocked hold
    '{1'b1, 12'h600, 32'hFF},
    '{1'b0, 12'h600, 32'h0},          // R9 unmapped read
    '{1'b1, 12'h501, 32'hFF},
    '{1'b0, 12'h500, 32'h0C},         // R9 misaligned offset ignored
    '{1'b0, 12'h504, 32'hF3},         // R9 pull-up untouched
    '{1'b0, 12'h524, 32'hF0}          // R9 mask untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 chk(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 R7 reset state on outputs
    chk("R10 alt", {24'h0, alt_sel}, 32'h0F);
    chk("R10 pu", {24'h0, pull_up}, 32'h00);
    chk("R10 pd", {24'h0, pull_dn}, 32'h00);
    chk("R10 den", {24'h0, dig_en}, 32'h0F);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_wr(VEC[i].addr, VEC[i].data);
      else do_rd($sformatf("vec%0d", i), VEC[i].addr, VEC[i].data);
    end

    // R1 output ports follow registers
    chk("R1 alt_sel_o", {24'h0, alt_sel}, 32'h0C);
    chk("R1 pull_up_o", {24'h0, pull_up}, 32'hF3);
    chk("R1 pull_dn_o", {24'h0, pull_dn}, 32'h52);

    // R8 read data zero without strobe
    @(negedge clk);
    addr = 12'h504; rd_en = 1'b0;
    #1 chk("R8 no strobe", rdata, 32'h0);

    // R8 write lands at the sampling edge, not before
    @(negedge clk);
    addr = 12'h504; wdata = 32'h00; wr_en = 1'b1;
    #1 chk("R8 before edge", {24'h0, pull_up}, 32'hF3);
    @(posedge clk);
    #1 chk("R8 after edge", {24'h0, pull_up}, 32'h03);
    @(negedge clk);
    wr_en = 1'b0;

    // R10 async reset between edges
    do_wr(12'h520, 32'h4C4F434B);
    do_wr(12'h524, 32'h0F);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R10 async alt", {24'h0, alt_sel}, 32'h0F);
    chk("R10 async pu", {24'h0, pull_up}, 32'h00);
    chk("R10 async pd", {24'h0, pull_dn}, 32'h00);
    chk("R10 async den", {24'h0, dig_en}, 32'h0F);
    @(negedge clk);
    rst_ni = 1'b1;
    do_rd("R10 lock relocked", 12'h520, 32'h1);
    do_rd("R10 mask reset", 12'h524, 32'hF0);

    finish_run();
  end
endmodule